// File: doc/BRIEF.md
# SPI Command Response Checker

This block sits on the receive side of an SPI host controller. Once the host has shifted out a command frame, the checker takes over the receive byte stream. It asks for one byte at a time through a request/valid handshake and checks the bytes against what the peripheral must send back. It reports a single ok or fail verdict. The frame builder and any payload capture logic live elsewhere. The checker only decides whether the peripheral acknowledged the command correctly.

The block has two modes. In command mode the checker first drops one byte if the opcode is a control opcode. It then hunts for the opcode echo and after that for a zero status byte. Each hunt runs under its own bounded retry budget. In trailer mode, used after a block write has streamed its payload, the checker reads a short fixed-length trailer. It checks the last two bytes of that trailer for the acknowledge pattern. In either mode a bus error ends the run at once with a fail.

Top module: `spi_rsp_checker`

## Requirements
- R1: After reset, `busy`, `rdReq`, `done`, `pass` and `fail` are all 0.
- R2: In command mode (`modeTrail`=0), the opcodes 0xCF, 0xC5 and 0xC6 make the checker discard exactly one received byte, whatever its value, before the echo hunt. Every other opcode starts the echo hunt with the first byte.
- R3: The echo hunt consumes bytes until one equals the latched opcode. It reads at most 1+RETRY_LIMIT bytes (11 by default). If none matches, the run ends with fail.
- R4: After the echo, the status hunt consumes bytes until one equals 0x00, under a freshly reloaded budget of 1+RETRY_LIMIT bytes. A match ends the run with pass. Exhausting the budget ends it with fail.
- R5: In trailer mode (`modeTrail`=1), the checker consumes 2 bytes when `crcOn`=1 and 3 bytes when `crcOn`=0. It passes only if the final byte is 0x00 and the byte just before it is 0xC3.
- R6: When `busErr` is high while busy, the run ends with fail on that clock edge, and no byte is consumed in that cycle.
- R7: A byte is consumed only on a cycle where `rdReq` and `rdValid` are both high. A `rdValid` while `rdReq` is low has no effect.
- R8: `done` is a one-cycle pulse that rises on the same edge that consumes the deciding byte. Exactly one of `pass`/`fail` is then high, and both hold until the next accepted `start`, which clears them.
- R9: A `start` that arrives while busy is ignored. The running check finishes with the same result and byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check (accepted only when idle) |
| modeTrail | input | 1 | 0: command response check, 1: write trailer check |
| opcode | input | 8 | Command opcode expected as echo |
| crcOn | input | 1 | Trailer length select: 1 gives 2 bytes, 0 gives 3 bytes |
| rdReq | output | 1 | Request for one received byte |
| rdValid | input | 1 | Received byte available on `rdData` |
| rdData | input | 8 | Received byte |
| busErr | input | 1 | Receive path error; aborts with fail |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle end-of-check pulse |
| pass | output | 1 | Held ok verdict |
| fail | output | 1 | Held fail verdict |

## Verification
The `start` pulse is registered: `rdReq` rises on the edge that takes `start`, and each byte is taken on the edge where `rdReq` and `rdValid` meet. The verdict and `done` change on the very edge that takes the deciding byte, or on the edge that samples `busErr`. The bench drives at falling edges and samples there too, and it requires `done` at the first falling edge after the last handshake. It then checks one falling edge later that `done` has dropped while the verdict holds. It also counts the handshakes in each run and compares them with the byte count worked out arithmetically from the stimulus.

// File: rtl/rsp_chk_pkg.sv
package rsp_chk_pkg;

  localparam int BYTE_W = 8;

  // Control opcodes that are preceded by one discarded byte
  localparam logic [BYTE_W-1:0] OP_CTL_RESET  = 8'hCF;
  localparam logic [BYTE_W-1:0] OP_CTL_TERM   = 8'hC5;
  localparam logic [BYTE_W-1:0] OP_CTL_REPEAT = 8'hC6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_ECHO,
    ST_STAT,
    ST_TRAIL
  } chkState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // clear verdict, latch opcode
    logic loadRetry;  // reload retry budget
    logic loadTrail;  // load trailer length
    logic decCnt;     // consume one budget step
    logic shiftByte;  // remember the byte just taken
    logic setPass;
    logic setFail;
  } chkStrb_t;

  function automatic logic isControlOp(input logic [BYTE_W-1:0] op);
    return (op == OP_CTL_RESET) || (op == OP_CTL_TERM) || (op == OP_CTL_REPEAT);
  endfunction

endpackage

// File: rtl/rsp_chk_dp.sv
module rsp_chk_dp
  import rsp_chk_pkg::*;
#(
  parameter int RETRY_LIMIT   = 10,
  parameter int TRAIL_LEN_CRC = 2,
  parameter int TRAIL_LEN_RAW = 3,
  parameter logic [7:0] STATUS_OK  = 8'h00,
  parameter logic [7:0] TRAIL_MARK = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  chkStrb_t          strb,
  input  logic [BYTE_W-1:0] opcodeIn,
  input  logic              crcOnIn,
  input  logic [BYTE_W-1:0] rdData,
  output logic              ctrlOp,
  output logic              cntZero,
  output logic              echoHit,
  output logic              statHit,
  output logic              trailOk,
  output logic              pass,
  output logic              fail,
  output logic              done
);

  localparam int MAX_TRAIL = (TRAIL_LEN_RAW > TRAIL_LEN_CRC) ? TRAIL_LEN_RAW : TRAIL_LEN_CRC;
  localparam int MAX_LOAD  = (RETRY_LIMIT > MAX_TRAIL - 1) ? RETRY_LIMIT : MAX_TRAIL - 1;
  localparam int CNT_W     = (MAX_LOAD < 1) ? 1 : $clog2(MAX_LOAD + 1);
  localparam logic [CNT_W-1:0] RETRY_LOAD = CNT_W'(RETRY_LIMIT);
  localparam logic [CNT_W-1:0] TRL_CRC    = CNT_W'(TRAIL_LEN_CRC - 1);
  localparam logic [CNT_W-1:0] TRL_RAW    = CNT_W'(TRAIL_LEN_RAW - 1);

  logic [BYTE_W-1:0] opReg;
  logic [BYTE_W-1:0] prevByte;
  logic [CNT_W-1:0]  cnt;

  // Opcode latch, taken when a check is accepted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg <= '0;
    end else if (strb.capture) begin
      opReg <= opcodeIn;
    end
  end

  // Shared budget / length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.loadRetry) begin
      cnt <= RETRY_LOAD;
    end else if (strb.loadTrail) begin
      cnt <= crcOnIn ? TRL_CRC : TRL_RAW;
    end else if (strb.decCnt) begin
      cnt <= cnt - 1'b1;
    end
  end

  // Byte history for the trailer pattern
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevByte <= '0;
    end else if (strb.shiftByte) begin
      prevByte <= rdData;
    end
  end

  // Verdict registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pass <= 1'b0;
      fail <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= strb.setPass | strb.setFail;
      if (strb.capture) begin
        pass <= 1'b0;
        fail <= 1'b0;
      end else begin
        if (strb.setPass) pass <= 1'b1;
        if (strb.setFail) fail <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrlOp  = isControlOp(opcodeIn);
    cntZero = (cnt == '0);
    echoHit = (rdData == opReg);
    statHit = (rdData == STATUS_OK);
    trailOk = (prevByte == TRAIL_MARK) && (rdData == STATUS_OK);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(MAX_LOAD)) else $error("budget counter out of range"); // R3

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(pass && fail)) else $error("pass and fail both set"); // R8

  AST_DONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass != fail)) else $error("done without single verdict"); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R8

endmodule

// File: rtl/rsp_chk_ctrl.sv
module rsp_chk_ctrl
  import rsp_chk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     modeTrail,
  input  logic     busErr,
  input  logic     rdValid,
  input  logic     ctrlOp,
  input  logic     cntZero,
  input  logic     echoHit,
  input  logic     statHit,
  input  logic     trailOk,
  output chkStrb_t strb,
  output logic     rdReq,
  output logic     busy
);

  chkState_t state, stateNxt;
  logic accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNxt;
    end
  end

  assign busy   = (state != ST_IDLE);
  assign rdReq  = busy;
  assign accept = rdReq && rdValid;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    if (state == ST_IDLE) begin
      if (start) begin
        strb.capture = 1'b1;
        if (modeTrail) begin
          strb.loadTrail = 1'b1;
          stateNxt       = ST_TRAIL;
        end else begin
          strb.loadRetry = 1'b1;
          stateNxt       = ctrlOp ? ST_SKIP : ST_ECHO;
        end
      end
    end else if (busErr) begin
      strb.setFail = 1'b1;
      stateNxt     = ST_IDLE;
    end else if (accept) begin
      unique case (state)
        ST_SKIP: stateNxt = ST_ECHO;
        ST_ECHO: begin
          if (echoHit) begin
            strb.loadRetry = 1'b1;
            stateNxt       = ST_STAT;
          end else if (cntZero) begin
            strb.setFail = 1'b1;
            stateNxt     = ST_IDLE;
          end else begin
            strb.decCnt = 1'b1;
          end
        end
        ST_STAT: begin
          if (statHit) begin
            strb.setPass = 1'b1;
            stateNxt     = ST_IDLE;
          end else if (cntZero) begin
            strb.setFail = 1'b1;
            stateNxt     = ST_IDLE;
          end else begin
            strb.decCnt = 1'b1;
          end
        end
        ST_TRAIL: begin
          strb.shiftByte = 1'b1;
          if (cntZero) begin
            strb.setPass = trailOk;
            strb.setFail = !trailOk;
            stateNxt     = ST_IDLE;
          end else begin
            strb.decCnt = 1'b1;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  AST_BUSERR_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busErr) |=> !busy) else $error("bus error did not end the check"); // R6

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !busErr && !rdValid) |=> busy) else $error("start disturbed a running check"); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !rdValid && !busErr) |=> (state == $past(state))) else $error("state moved without a byte"); // R7

endmodule

// File: rtl/spi_rsp_checker.sv
module spi_rsp_checker
  import rsp_chk_pkg::*;
#(
  parameter int RETRY_LIMIT   = 10,
  parameter int TRAIL_LEN_CRC = 2,
  parameter int TRAIL_LEN_RAW = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       modeTrail,
  input  logic [7:0] opcode,
  input  logic       crcOn,
  output logic       rdReq,
  input  logic       rdValid,
  input  logic [7:0] rdData,
  input  logic       busErr,
  output logic       busy,
  output logic       done,
  output logic       pass,
  output logic       fail
);

  chkStrb_t strb;
  logic ctrlOp, cntZero, echoHit, statHit, trailOk;

  rsp_chk_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .modeTrail(modeTrail),
    .busErr   (busErr),
    .rdValid  (rdValid),
    .ctrlOp   (ctrlOp),
    .cntZero  (cntZero),
    .echoHit  (echoHit),
    .statHit  (statHit),
    .trailOk  (trailOk),
    .strb     (strb),
    .rdReq    (rdReq),
    .busy     (busy)
  );

  rsp_chk_dp #(
    .RETRY_LIMIT  (RETRY_LIMIT),
    .TRAIL_LEN_CRC(TRAIL_LEN_CRC),
    .TRAIL_LEN_RAW(TRAIL_LEN_RAW)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .opcodeIn(opcode),
    .crcOnIn (crcOn),
    .rdData  (rdData),
    .ctrlOp  (ctrlOp),
    .cntZero (cntZero),
    .echoHit (echoHit),
    .statHit (statHit),
    .trailOk (trailOk),
    .pass    (pass),
    .fail    (fail),
    .done    (done)
  );

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(pass) && $stable(fail))) else $error("verdict changed while idle"); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !rdReq)) else $error("done while still requesting"); // R8

endmodule

// File: tb/tb_spi_rsp_checker.sv
module tb_spi_rsp_checker;

  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 10;
  localparam int NBUF       = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       modeTrail = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic       crcOn = 1'b0;
  logic       rdReq;
  logic       rdValid = 1'b0;
  logic [7:0] rdData = 8'h00;
  logic       busErr = 1'b0;
  logic       busy, done, pass, fail;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  logic [7:0] rxBytes [NBUF];

  spi_rsp_checker #(.RETRY_LIMIT(LIM)) dut (
    .clk(clk), .rstN(rstN), .start(start), .modeTrail(modeTrail),
    .opcode(opcode), .crcOn(crcOn), .rdReq(rdReq), .rdValid(rdValid),
    .rdData(rdData), .busErr(busErr), .busy(busy), .done(done),
    .pass(pass), .fail(fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit isCtl(input logic [7:0] op);
    return (op == 8'hCF) || (op == 8'hC5) || (op == 8'hC6);
  endfunction

  // Independent expectation from the requirements
  function automatic void model(input bit mode, input logic [7:0] op, input bit crc,
                                output bit ok, output int used);
    int i;
    int tries;
    bit hit;
    if (mode) begin
      used = crc ? 2 : 3;
      ok   = (rxBytes[used-1] == 8'h00) && (rxBytes[used-2] == 8'hC3);
      return;
    end
    i = isCtl(op) ? 1 : 0;          // R2 discard
    hit = 1'b0;
    for (tries = 0; tries <= LIM; tries++) begin
      if (rxBytes[i] == op) begin hit = 1'b1; i++; break; end
      i++;
    end
    if (!hit) begin ok = 1'b0; used = i; return; end   // R3
    hit = 1'b0;
    for (tries = 0; tries <= LIM; tries++) begin
      if (rxBytes[i] == 8'h00) begin hit = 1'b1; i++; break; end
      i++;
    end
    ok = hit; used = i;                                // R4
  endfunction

  // One full check; errAt < 0 means no bus error
  task automatic runCase(input bit mode, input logic [7:0] op, input bit crc,
                         input bit gapOn, input int errAt, input bit injStart, input string tag);
    bit expOk;
    int expUsed;
    int idx = 0;
    int cyc = 0;
    bit drove;
    bit lastEv = 1'b0;
    bit gotDone = 1'b0;
    bit errDone = 1'b0;
    model(mode, op, crc, expOk, expUsed);
    if (errAt >= 0) begin expOk = 1'b0; expUsed = errAt; end
    @(negedge clk);
    modeTrail = mode; opcode = op; crcOn = crc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cyc < 200) begin
      if (done) begin gotDone = 1'b1; break; end
      start = (injStart && cyc == 1);
      if (injStart && cyc == 1) begin modeTrail = ~mode; opcode = 8'h00; end
      drove = 1'b0;
      if (errAt >= 0 && idx == errAt && !errDone) begin
        busErr = 1'b1; errDone = 1'b1; rdValid = 1'b0; rdData = 8'hEE;
      end else if (rdReq && !(gapOn && (cyc % 3 == 1))) begin
        rdValid = 1'b1; rdData = (idx < NBUF) ? rxBytes[idx] : 8'h5A; drove = 1'b1;
      end else begin
        rdValid = 1'b0; rdData = 8'hEE;
      end
      lastEv = drove || busErr;
      @(posedge clk);
      if (drove) idx++;
      @(negedge clk);
      busErr = 1'b0; start = 1'b0; rdValid = 1'b0;
      cyc++;
    end
    check(gotDone, {tag, " R8 done seen"}, gotDone, 1);
    check(lastEv, {tag, " R8 done right after deciding edge"}, lastEv, 1);
    check(pass == expOk && fail == !expOk, {tag, " R3 R4 R5 R6 verdict"}, {pass, fail}, {expOk, !expOk});
    check(idx == expUsed, {tag, " R2 R7 bytes consumed"}, idx, expUsed);
    @(negedge clk);
    check(!done && pass == expOk && fail == !expOk && !busy, {tag, " R8 pulse/hold"},
          {done, pass, fail, busy}, {1'b0, expOk, !expOk, 1'b0});
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nBad++;
      nVec++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] ops [11];
    logic [7:0] tv [3];
    int s0;
    int k = 0;
    ops = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7, 8'hC8, 8'hC9, 8'hCA, 8'hCF};
    tv  = '{8'h00, 8'hC3, 8'h01};
    repeat (3) @(negedge clk);
    check(!busy && !rdReq && !done && !pass && !fail, "R1 reset state",
          {busy, rdReq, done, pass, fail}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !rdReq && !done && !pass && !fail, "R1 after release",
          {busy, rdReq, done, pass, fail}, 0);

    // R7: valid while idle does nothing
    for (int j = 0; j < 4; j++) begin
      rdValid = 1'b1; rdData = 8'h00;
      @(negedge clk);
      check(!busy && !rdReq && !done && !pass && !fail, "R7 idle valid ignored",
            {busy, rdReq, done, pass, fail}, 0);
    end
    rdValid = 1'b0;

    // R2 R3 R4: sweep opcode x echo position x status position
    for (int o = 0; o < 11; o++) begin
      for (int p = 0; p <= LIM + 1; p++) begin
        for (int q = 0; q <= LIM + 1; q++) begin
          if (p == LIM + 1 && q > 0) continue;
          for (int i = 0; i < NBUF; i++) rxBytes[i] = 8'h10 + 8'(i);
          s0 = isCtl(ops[o]) ? 1 : 0;
          if (s0 == 1) rxBytes[0] = k[0] ? ops[o] : 8'h00;
          if (p <= LIM) rxBytes[s0 + p] = ops[o];
          if (p <= LIM && q <= LIM) rxBytes[s0 + p + 1 + q] = 8'h00;
          runCase(1'b0, ops[o], 1'b0, k[1], -1, 1'b0, "cmd sweep");
          k++;
        end
      end
    end

    // R5: trailer sweep
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          for (int d = 0; d < 3; d++) begin
            for (int i = 0; i < NBUF; i++) rxBytes[i] = 8'h77;
            rxBytes[0] = tv[a]; rxBytes[1] = tv[b]; rxBytes[2] = tv[d];
            runCase(1'b1, 8'hC7, c[0], d[0], -1, 1'b0, "R5 trailer");
          end

    // R6: bus error at each byte position, with and without stalls
    for (int e = 0; e < 8; e++) begin
      for (int i = 0; i < NBUF; i++) rxBytes[i] = 8'h20 + 8'(i);
      rxBytes[3] = 8'hC9; rxBytes[7] = 8'h00;
      runCase(1'b0, 8'hC9, 1'b0, e[0], e, 1'b0, "R6 bus error cmd");
    end
    for (int e = 0; e < 2; e++) begin
      rxBytes[0] = 8'h11; rxBytes[1] = 8'hC3; rxBytes[2] = 8'h00;
      runCase(1'b1, 8'h00, 1'b0, 1'b0, e, 1'b0, "R6 bus error trailer");
    end

    // R9: start while busy is ignored
    for (int i = 0; i < NBUF; i++) rxBytes[i] = 8'h30 + 8'(i);
    rxBytes[0] = 8'h55; rxBytes[5] = 8'hC5; rxBytes[8] = 8'h00;
    runCase(1'b0, 8'hC5, 1'b0, 1'b0, -1, 1'b1, "R9 restart ignored");
    rxBytes[0] = 8'hC3; rxBytes[1] = 8'h00; rxBytes[2] = 8'h44;
    runCase(1'b1, 8'h00, 1'b1, 1'b1, -1, 1'b1, "R9 restart ignored trailer");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule